// File: doc/BRIEF.md
# Watchdog Configuration Serial Command Port

This block is the serial configuration front end of a supervisor watchdog. A host talks to it as an SPI mode 0 slave using single-byte instructions. These instructions arm or disarm a change-permission latch, write the watchdog control byte, or read that byte back. The two meaningful bits of the control byte feed the watchdog timer directly, and they select its timeout range.

A write is deliberately hard to issue by accident. The permission latch must already be armed. The frame must end with chip select rising after exactly sixteen bits. The data byte must keep its reserved bits clear. An accepted write starts a self-timed busy window that models a nonvolatile store. While that window is open, a read answers all ones and the arm, disarm and write instructions are ignored. The latch drops by itself once a write is accepted.

The SPI pins are sampled in the system clock domain, so the SCK rate must stay well below that clock. The power-on reset input clears the permission latch. After reset, the port stays deaf until it sees chip select fall.

Top module: `wdcfg_spi_slave`

## Requirements
- R1: After reset, wd_sel_o equals the parameter SEL_INIT (default 2'b00), so_oe_o is 0 and the permission latch is clear.
- R2: After reset, no instruction is acted on until cs_ni has been seen to go from high to low; bytes clocked while chip select was already low at reset have no effect.
- R3: Opcode 8'h05 makes the block shift out the control byte MSB first, with so_o updated on SCK falling edges, starting at the falling edge after the eighth bit. The byte reads as {3'b000, wd_sel, 3'b000}. so_oe_o is 1 only during that read frame after decode, and is 0 while chip select is high and during any other instruction.
- R4: Opcode 8'h01 followed by a data byte loads data bits 4:3 into wd_sel_o when chip select rises. Bit 4 is the upper select bit. This happens only if the latch was armed, exactly 16 bits were clocked, and no write is in progress.
- R5: A write without a prior arm leaves wd_sel_o unchanged.
- R6: An accepted write clears the permission latch, so that a second write needs a new arm.
- R7: Opcode 8'h06 arms the latch, and opcode 8'h04 disarms it.
- R8: A write frame that ends at a bit count other than 16 is discarded and leaves the latch as it was.
- R9: A write whose data byte has any of bits 7:5 or 2:0 set is discarded and leaves the latch armed.
- R10: An accepted write opens a busy window of BUSY_CYCLES clock cycles. A read that decodes inside this window returns 8'hFF, and a read after it returns the stored byte.
- R11: Arm, disarm and write instructions that decode during the busy window have no effect.
- R12: An unknown opcode makes the rest of that frame be ignored, including any valid opcode that follows in the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sck_i | input | 1 | Serial clock, idle low |
| si_i | input | 1 | Serial data in, sampled on SCK rising edge |
| cs_ni | input | 1 | Active-low chip select |
| so_o | output | 1 | Serial data out, changes on SCK falling edge |
| so_oe_o | output | 1 | Output enable for so_o; 0 means high impedance |
| wd_sel_o | output | 2 | Watchdog timeout select bits to the timer |

## Verification
The checker watches several behaviours on every cycle. The select bits may move only in the cycle after an accepted commit. A commit needs an armed latch and an idle store timer, it always opens the busy window, and it always leaves the latch clear. The output enable never rises while unselected or before the port has been armed by a chip-select fall. The serial ordering of the read byte, the all-ones answer during the busy window, bit-count and reserved-bit rejection, and the deafness after an unknown opcode are framing properties. Only the bench's directed frames, checked at the pins, can show them.

// File: rtl/wdcfg_pkg.sv
package wdcfg_pkg;
  localparam logic [7:0] OPC_ARM    = 8'h06;
  localparam logic [7:0] OPC_DISARM = 8'h04;
  localparam logic [7:0] OPC_WRITE  = 8'h01;
  localparam logic [7:0] OPC_READ   = 8'h05;

  localparam int unsigned SEL_LSB    = 3;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned FRAME_BITS = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] SEL_MASK  = ((1 << SEL_W) - 1) << SEL_LSB;
  localparam logic [BYTE_W-1:0] RSVD_MASK = ~SEL_MASK;

  typedef enum logic [1:0] {
    MD_OPCODE = 2'd0,
    MD_WRITE  = 2'd1,
    MD_READ   = 2'd2,
    MD_DONE   = 2'd3
  } mode_e;
endpackage

// File: rtl/wdcfg_pin_sync.sv
module wdcfg_pin_sync #(
  parameter int unsigned NPIN = 3,
  parameter logic [NPIN-1:0] RST_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] lvl_o,
  output logic [NPIN-1:0] rise_o,
  output logic [NPIN-1:0] fall_o
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= RST_VAL[g];
        s2_q   <= RST_VAL[g];
        prev_q <= RST_VAL[g];
      end else begin
        s1_q   <= pin_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~prev_q;
    assign fall_o[g] = ~s2_q & prev_q;
  end
endmodule

// File: rtl/wdcfg_busy_timer.sv
module wdcfg_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/wdcfg_cmd.sv
module wdcfg_cmd
  import wdcfg_pkg::*;
#(
  parameter logic [SEL_W-1:0] SEL_INIT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sck_rise_i,
  input  logic             sck_fall_i,
  input  logic             si_i,
  input  logic             busy_i,
  output logic             armed_o,
  output logic             rd_mode_o,
  output logic             commit_o,
  output logic             latch_o,
  output logic [SEL_W-1:0] wd_sel_o,
  output logic             so_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + BYTE_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS);

  logic              armed_q, latch_q, fill_q, so_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q, data_q, tx_q;
  logic [SEL_W-1:0]  sel_q;
  mode_e             mode_q;
  logic [BYTE_W-1:0] byte_w;
  logic [BYTE_W-1:0] rd_byte_w;

  assign byte_w    = {shreg_q[BYTE_W-2:0], si_i};
  assign rd_byte_w = BYTE_W'(sel_q) << SEL_LSB;

  assign commit_o = cs_rise_i && armed_q && (mode_q == MD_WRITE) &&
                    (bit_cnt_q == FRAME_END) && latch_q && !busy_i &&
                    ((data_q & RSVD_MASK) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      latch_q   <= 1'b0;
      fill_q    <= 1'b0;
      so_q      <= 1'b0;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      data_q    <= '0;
      tx_q      <= '0;
      sel_q     <= SEL_INIT;
      mode_q    <= MD_DONE;
    end else if (cs_fall_i) begin
      armed_q   <= 1'b1;
      bit_cnt_q <= '0;
      mode_q    <= MD_OPCODE;
    end else if (cs_rise_i) begin
      if (commit_o) begin
        sel_q   <= data_q[SEL_LSB +: SEL_W];
        latch_q <= 1'b0;
      end
      mode_q <= MD_DONE;
    end else if (armed_q && sel_i && sck_rise_i) begin
      shreg_q <= byte_w;
      if (bit_cnt_q != CNT_MAX) bit_cnt_q <= bit_cnt_q + 1'b1;
      if (mode_q == MD_OPCODE && bit_cnt_q == OPC_LAST) begin
        unique case (byte_w)
          OPC_ARM: begin
            if (!busy_i) latch_q <= 1'b1;
            mode_q <= MD_DONE;
          end
          OPC_DISARM: begin
            if (!busy_i) latch_q <= 1'b0;
            mode_q <= MD_DONE;
          end
          OPC_WRITE: mode_q <= busy_i ? MD_DONE : MD_WRITE;
          OPC_READ: begin
            mode_q <= MD_READ;
            tx_q   <= busy_i ? '1 : rd_byte_w;
            fill_q <= busy_i;
          end
          default: mode_q <= MD_DONE;  // unknown: deaf until CS rises
        endcase
      end
      if (mode_q == MD_WRITE && bit_cnt_q == DATA_LAST) data_q <= byte_w;
    end else if (armed_q && sel_i && sck_fall_i && mode_q == MD_READ) begin
      so_q <= tx_q[BYTE_W-1];
      tx_q <= {tx_q[BYTE_W-2:0], fill_q};
    end
  end

  assign armed_o   = armed_q;
  assign rd_mode_o = armed_q && sel_i && (mode_q == MD_READ);
  assign latch_o   = latch_q;
  assign wd_sel_o  = sel_q;
  assign so_o      = so_q;
endmodule

// File: rtl/wdcfg_spi_slave.sv
module wdcfg_spi_slave
  import wdcfg_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1000,
  parameter logic [1:0]  SEL_INIT    = 2'b00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       si_i,
  input  logic       cs_ni,
  output logic       so_o,
  output logic       so_oe_o,
  output logic [1:0] wd_sel_o
);
  localparam int unsigned NPIN = 3;
  // pin order {cs_n, si, sck}; cs_n resets low so a CS held low at reset
  // yields no falling edge and the port stays unarmed.
  localparam logic [NPIN-1:0] PIN_RST = 3'b000;

  logic [NPIN-1:0] lvl_w, rise_w, fall_w;
  logic busy_w, armed_w, rd_mode_w, commit_w, latch_w;

  wdcfg_pin_sync #(.NPIN(NPIN), .RST_VAL(PIN_RST)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({cs_ni, si_i, sck_i}),
    .lvl_o  (lvl_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  wdcfg_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit_w),
    .busy_o  (busy_w)
  );

  wdcfg_cmd #(.SEL_INIT(SEL_INIT)) i_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (~lvl_w[2]),
    .cs_fall_i  (fall_w[2]),
    .cs_rise_i  (rise_w[2]),
    .sck_rise_i (rise_w[0]),
    .sck_fall_i (fall_w[0]),
    .si_i       (lvl_w[1]),
    .busy_i     (busy_w),
    .armed_o    (armed_w),
    .rd_mode_o  (rd_mode_w),
    .commit_o   (commit_w),
    .latch_o    (latch_w),
    .wd_sel_o   (wd_sel_o),
    .so_o       (so_o)
  );

  assign so_oe_o = rd_mode_w;
endmodule

// File: rtl/wdcfg_spi_checker.sv
module wdcfg_spi_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_sel,
  input logic       so_oe_o,
  input logic [1:0] wd_sel_o,
  input logic       armed,
  input logic       commit,
  input logic       latch,
  input logic       busy
);
  AST_SEL_MOVES_ONLY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wd_sel_o) |-> $past(commit)); // R4
  AST_COMMIT_NEEDS_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> latch); // R5
  AST_COMMIT_CLEARS_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !latch); // R6
  AST_COMMIT_OPENS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy); // R10
  AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !commit); // R11
  AST_OE_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> cs_sel); // R3
  AST_UNARMED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (!so_oe_o && !commit)); // R2
endmodule

bind wdcfg_spi_slave wdcfg_spi_checker i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_sel   (~lvl_w[2]),
  .so_oe_o  (so_oe_o),
  .wd_sel_o (wd_sel_o),
  .armed    (armed_w),
  .commit   (commit_w),
  .latch    (latch_w),
  .busy     (busy_w)
);

// File: tb/test_wdcfg_spi_slave.sv
module test_wdcfg_spi_slave;
  localparam int BUSY = 2000;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b0;
  logic so, so_oe;
  logic [1:0] wd_sel;
  int n_chk = 0, n_err = 0;
  logic [23:0] rx, oe;

  always #5 clk = ~clk;

  wdcfg_spi_slave #(.BUSY_CYCLES(BUSY), .SEL_INIT(2'b00)) i_wdcfg_spi_slave (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .si_i(si), .cs_ni(cs_n),
    .so_o(so), .so_oe_o(so_oe), .wd_sel_o(wd_sel)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input int nbits, input logic [23:0] tx);
    for (int b = 0; b < nbits; b++) begin
      si = tx[23-b];
      tick(HALF);
      rx[23-b] = so;
      oe[23-b] = so_oe;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input int nbytes, input logic [23:0] tx);
    rx = '0; oe = '0;
    cs_n = 1'b0;
    tick(HALF);
    shift_bits(nbytes * 8, tx);
    tick(HALF);
    cs_n = 1'b1;
    tick(10);
  endtask

  task automatic t_reset;
    tick(3);
    chk("R1 wd_sel", 32'(wd_sel), 32'h0);
    chk("R1 so_oe", 32'(so_oe), 32'h0);
  endtask

  task automatic t_unarmed;
    // CS low through reset: arm opcode must be ignored
    shift_bits(8, 24'h060000);
    tick(HALF); cs_n = 1'b1; tick(10);
    xfer(2, 24'h011000);
    chk("R2 arm before first CS fall ignored", 32'(wd_sel), 32'h0);
  endtask

  task automatic t_read_idle;
    xfer(2, 24'h05A500);
    chk("R3 read byte", 32'(rx[15:8]), 32'h00);
    chk("R3 oe off during opcode", 32'(oe[23:16]), 32'h00);
    chk("R3 oe on during data", 32'(oe[15:8]), 32'hFF);
    chk("R3 oe off with CS high", 32'(so_oe), 32'h0);
    xfer(1, 24'h060000);
    chk("R3 oe off for non-read", 32'(oe[23:16]), 32'h00);
    xfer(1, 24'h040000);
  endtask

  task automatic t_write_ok;
    xfer(1, 24'h060000);
    xfer(2, 24'h011000);
    chk("R4 write accepted", 32'(wd_sel), 32'h2);
    tick(BUSY + 50);
    xfer(2, 24'h050000);
    chk("R3 read after write", 32'(rx[15:8]), 32'h10);
  endtask

  task automatic t_no_arm;
    xfer(2, 24'h010800);
    chk("R5 R6 write without fresh arm", 32'(wd_sel), 32'h2);
  endtask

  task automatic t_disarm;
    xfer(1, 24'h060000);
    xfer(1, 24'h040000);
    xfer(2, 24'h010800);
    chk("R7 disarm blocks write", 32'(wd_sel), 32'h2);
  endtask

  task automatic t_bad_count;
    xfer(1, 24'h060000);
    xfer(3, 24'h010800);
    chk("R8 24-bit frame discarded", 32'(wd_sel), 32'h2);
    xfer(2, 24'h010800);
    chk("R8 latch kept after bad count", 32'(wd_sel), 32'h1);
    tick(BUSY + 50);
  endtask

  task automatic t_reserved_and_busy;
    xfer(1, 24'h060000);
    xfer(2, 24'h010900);
    chk("R9 reserved bit discarded", 32'(wd_sel), 32'h1);
    xfer(2, 24'h011800);
    chk("R9 latch kept after reserved reject", 32'(wd_sel), 32'h3);
    xfer(2, 24'h050000);
    chk("R10 read while busy is FF", 32'(rx[15:8]), 32'hFF);
    xfer(1, 24'h060000);  // ignored: busy
    tick(BUSY + 50);
    xfer(2, 24'h010000);
    chk("R11 arm during busy ignored", 32'(wd_sel), 32'h3);
    xfer(2, 24'h050000);
    chk("R10 read after busy", 32'(rx[15:8]), 32'h18);
  endtask

  task automatic t_unknown;
    xfer(2, 24'h030600);
    xfer(2, 24'h010000);
    chk("R12 opcode after unknown ignored", 32'(wd_sel), 32'h3);
    xfer(1, 24'h060000);
    xfer(2, 24'h010000);
    chk("R12 normal arm still works", 32'(wd_sel), 32'h0);
  endtask

  initial begin
    tick(4);
    rst_ni = 1'b1;
    t_reset();
    t_unarmed();
    t_read_idle();
    t_write_ok();
    t_no_arm();
    t_disarm();
    t_bad_count();
    t_reserved_and_busy();
    t_unknown();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule